// File: doc/BRIEF.md
# Chained Up-Down LED Sweep Counter

This block drives a small LED value that climbs from zero to its maximum one step at a time, then falls back to zero, and keeps doing this forever without any input. The steps come from a slow tick. The tick is generated inside the block from the fast system clock as a one-cycle enable, so the whole block runs in a single clock domain. With the default settings, a 12 MHz clock gives one step about every 0.7 s.

The sweep is not made by one counter with a direction bit. It comes from two copies of one counter design. A parameter fixes each copy as an ascending or a descending counter. A counter starts a run when its go input is high and reports a one-cycle done when the run ends. The done of each counter is the go of the other, so the two counters hand the count back and forth.

Three small pieces of glue logic complete the block. A launch pulse, ORed into the ascending counter's go, starts the first run after reset. A select register flips on each done. A 2:1 multiplexer uses that select to pass the running counter's value to the LEDs. The parameters are `LED_WIDTH` (default 4) and `TICK_PERIOD` (default 8388608 clocks, at least 2).

Top module: `updown_led_top`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge (synchronous, active-low), `led_o` is 0 after that edge. It stays 0 for as long as reset is held.
- R2: A step happens only on a tick. The first tick is consumed at the `TICK_PERIOD`-th rising edge after reset is released (the first edge with `rst_n` high counts as edge 1). After that, a tick comes every `TICK_PERIOD` edges. Between ticks `led_o` holds its value.
- R3: After reset, `led_o` rises by exactly 1 on each tick, from 0 up to the maximum value 2^`LED_WIDTH`-1.
- R4: After the maximum, `led_o` falls by exactly 1 on each tick down to 0. The maximum is shown for exactly one tick period.
- R5: After reaching 0, `led_o` rises again, and 0 is shown for exactly one tick period. After n ticks the value is m when m = n mod (2*max) is at most max, and 2*max-m otherwise.
- R6: Each counter returns to idle in the cycle after its done. Done is high for exactly one cycle. An idle counter holds its start value: 0 for the ascending counter, the maximum for the descending one.
- R7: Exactly one launch pulse, one cycle wide, is produced on the first cycle after reset is released. Counting starts from it.
- R8: The select moves to the descending counter in the cycle after the ascending counter's done, and back after the descending counter's done. The two counters are never running at the same time.
- R9: A reset applied in the middle of a sweep restarts the sequence from 0, with the tick phase counted again from the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| led_o | output | LED_WIDTH | Current sweep value |

## Verification
The bench runs a short tick period and samples `led_o` on every cycle for three full sweeps, comparing it with the closed-form triangle value. It pays most attention to the two turnarounds. A handoff registered one cycle late would show the maximum or zero for two tick periods. A counter that did not reload its start value would resume from a stale value. A select that toggled on the wrong done would show the idle counter's value. The first step after reset is checked at its exact edge, so a launch pulse that is missing or doubled, or a divider that is off by one, moves the whole sequence. Reset is also held for several cycles and applied mid-sweep, to show that no counting starts under reset and that the phase restarts cleanly.

// File: rtl/updown_pkg.sv
// Shared types for the chained up-down sweep counter.
// Assumes: one clock domain, synchronous active-low reset everywhere.
package updown_pkg;

    // Run state of a single-direction counter
    typedef enum logic {
        CNT_IDLE = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_t;

    // Which counter owns the LED output
    typedef enum logic {
        SEL_UP   = 1'b0,
        SEL_DOWN = 1'b1
    } led_sel_t;

endpackage

// File: rtl/tick_gen.sv
// Slow tick generator: raises tick_o for one clock every TICK_PERIOD clocks.
// Assumes: TICK_PERIOD >= 2; the counter restarts from 0 on reset, so the
// first tick is high in the cycle after the TICK_PERIOD-1 th edge after release.
module tick_gen #(
    parameter int TICK_PERIOD = 8388608
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (TICK_PERIOD > 2) ? $clog2(TICK_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_PERIOD - 1);

    logic [CW-1:0] div_q;

    // Free-running divider that wraps at the last count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + CW'(1);
        end
    end

    assign tick_o = (div_q == LAST);

    // R2: ticks are never back to back
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o)
        else $error("tick high on two consecutive cycles");

    // R2: divider never leaves its range
    always_comb begin
        a_div_range_r2: assert (div_q <= LAST)
            else $error("divider out of range");
    end

endmodule

// File: rtl/launch_pulse.sv
// Launch pulse: a one-cycle start strobe on the first cycle after reset ends.
// Assumes: reset is held for at least one clock edge.
module launch_pulse (
    input  logic clk,
    input  logic rst_n,
    output logic start_o
);
    logic armed_q;

    // Armed under reset, disarmed on the first edge with reset released
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
        end else begin
            armed_q <= 1'b0;
        end
    end

    assign start_o = armed_q;

    // R7: the launch strobe is one cycle wide
    p_start_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o)
        else $error("launch pulse wider than one cycle");

    // R7: once gone, the strobe never returns without a reset
    p_start_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !start_o |=> !start_o)
        else $error("second launch pulse");

endmodule

// File: rtl/dir_counter.sv
// Single-direction counter with a go/done handshake.
// COUNT_UP=1 counts 0 -> max, COUNT_UP=0 counts max -> 0.
// When idle it holds its start value. On go it begins running and steps once
// per tick. The tick that would produce the terminal value raises done
// (combinational, one cycle), reloads the start value and returns to idle.
// The partner counter therefore shows the terminal value.
// Assumes: go is ignored while running; tick is a one-cycle enable.
module dir_counter
    import updown_pkg::*;
#(
    parameter int WIDTH    = 4,
    parameter bit COUNT_UP = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             go_i,
    output logic [WIDTH-1:0] value_o,
    output logic             done_o,
    output logic             busy_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] START_V  = COUNT_UP ? '0 : ALL_ONES;
    localparam logic [WIDTH-1:0] TERM_V   = COUNT_UP ? ALL_ONES : '0;

    cnt_state_t       state_q;
    logic [WIDTH-1:0] value_q;
    logic [WIDTH-1:0] next_v;

    // Direction picked at elaboration
    generate
        if (COUNT_UP) begin : g_up
            assign next_v = value_q + WIDTH'(1);
        end else begin : g_down
            assign next_v = value_q - WIDTH'(1);
        end
    endgenerate

    assign done_o  = (state_q == CNT_RUN) && tick_i && (next_v == TERM_V);
    assign busy_o  = (state_q == CNT_RUN);
    assign value_o = value_q;

    // Run/idle state machine and the count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CNT_IDLE;
            value_q <= START_V;
        end else begin
            case (state_q)
                CNT_IDLE: begin
                    value_q <= START_V;
                    if (go_i) begin
                        state_q <= CNT_RUN;
                    end
                end
                CNT_RUN: begin
                    if (done_o) begin
                        state_q <= CNT_IDLE;
                        value_q <= START_V;
                    end else if (tick_i) begin
                        value_q <= next_v;
                    end
                end
                default: state_q <= CNT_IDLE;
            endcase
        end
    end

    // R6: done lasts exactly one cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("done wider than one cycle");

    // R6: after done the counter is idle with its start value
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!busy_o && value_o == START_V))
        else $error("counter not idle at start value after done");

    // R2: a running counter moves only on a tick
    p_step_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tick_i) |=> $stable(value_o))
        else $error("counter moved without a tick");

endmodule

// File: rtl/updown_led_top.sv
// Chained up-down LED sweep counter.
// One ascending and one descending counter hand the run to each other through
// go/done. A launch pulse starts the first ascending run after reset, and a
// select register, flipped by each done, routes the running counter to led_o.
// Assumes: single clock, synchronous active-low reset, TICK_PERIOD >= 2,
// LED_WIDTH >= 2.
module updown_led_top
    import updown_pkg::*;
#(
    parameter int LED_WIDTH   = 4,
    parameter int TICK_PERIOD = 8388608
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [LED_WIDTH-1:0] led_o
);
    logic                 tick;
    logic                 start;
    logic                 up_go;
    logic                 up_done;
    logic                 up_busy;
    logic [LED_WIDTH-1:0] up_val;
    logic                 dn_done;
    logic                 dn_busy;
    logic [LED_WIDTH-1:0] dn_val;
    led_sel_t             sel_q;

    tick_gen #(
        .TICK_PERIOD(TICK_PERIOD)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_o(tick)
    );

    launch_pulse u_launch (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_o(start)
    );

    assign up_go = start | dn_done;

    dir_counter #(
        .WIDTH   (LED_WIDTH),
        .COUNT_UP(1'b1)
    ) u_up (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .go_i   (up_go),
        .value_o(up_val),
        .done_o (up_done),
        .busy_o (up_busy)
    );

    dir_counter #(
        .WIDTH   (LED_WIDTH),
        .COUNT_UP(1'b0)
    ) u_dn (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .go_i   (up_done),
        .value_o(dn_val),
        .done_o (dn_done),
        .busy_o (dn_busy)
    );

    // Select register: follows whichever counter just handed off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SEL_UP;
        end else if (up_done) begin
            sel_q <= SEL_DOWN;
        end else if (dn_done) begin
            sel_q <= SEL_UP;
        end
    end

    // Output multiplexer
    assign led_o = (sel_q == SEL_UP) ? up_val : dn_val;

    // R8: select moves to the descending counter after an ascending done
    p_sel_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        up_done |=> (sel_q == SEL_DOWN))
        else $error("select did not move to descending counter");

    // R8: select moves back after a descending done
    p_sel_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dn_done |=> (sel_q == SEL_UP))
        else $error("select did not move to ascending counter");

    // R8: never two runners
    p_one_runner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_busy && dn_busy))
        else $error("both counters running");

    // R2: LED holds between ticks
    p_led_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(led_o))
        else $error("LED changed without a tick");

    // R3/R4: every tick moves the LED by exactly one
    p_led_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ((led_o - $past(led_o)) == LED_WIDTH'(1)
               || ($past(led_o) - led_o) == LED_WIDTH'(1)))
        else $error("LED step not of size one");

endmodule

// File: tb/sim_updown_led_top.sv
`timescale 1ns/1ps
module sim_updown_led_top;
    localparam int W    = 4;
    localparam int P    = 4;
    localparam int MAXV = (1 << W) - 1;
    localparam int PER  = 2 * MAXV;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] led;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    updown_led_top #(
        .LED_WIDTH  (W),
        .TICK_PERIOD(P)
    ) u0 (
        .clk  (clk),
        .rst_n(rst_n),
        .led_o(led)
    );

    always #2.5 clk = ~clk;

    // Triangle value after n consumed ticks
    function automatic int tri_val(int n);
        int m = n % PER;
        return (m <= MAXV) ? m : PER - m;
    endfunction

    task automatic check(string req, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: led=%0d expected=%0d at %0t", req, got, exp, $time);
        end
    endtask

    // Release has been driven at a negedge; samples after each following edge
    task automatic sweep(int ncyc, bit restart_tag);
        for (int j = 0; j < ncyc; j++) begin
            int    n;
            int    m;
            string tag;
            @(negedge clk);
            n = (j + 1) / P;
            m = n % PER;
            if (restart_tag && j < 2 * P)      tag = "R9";
            else if ((j + 1) % P != 0)         tag = "R2";
            else if (n == 0)                   tag = "R7";
            else if (m == 0)                   tag = "R5,R6";
            else if (m == 1 && n > 1)          tag = "R5";
            else if (m == MAXV + 1)            tag = "R4,R8";
            else if (m <= MAXV)                tag = "R3";
            else                               tag = "R4";
            check(tag, int'(led), tri_val(n));
        end
    endtask

    initial begin
        // R1: reset state, held several cycles
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R1", int'(led), 0);
        end
        rst_n = 1'b1;
        // R7 first step edge exact; R2..R6,R8 over three sweeps
        sweep(3 * PER * P + 7, 1'b0);
        // R9: mid-sweep reset
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", int'(led), 0);
        for (int k = 0; k < 2 * P + 1; k++) begin
            @(negedge clk);
            check("R1", int'(led), 0);
        end
        rst_n = 1'b1;
        sweep(PER * P + 3 * P, 1'b1);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule